// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM that never needs an idle cycle between a read and a write on its data bus. Each word holds two or four bytes of nine bits. Every command input is sampled on the rising clock edge: address, read/write select, per-byte write masks, three chip enables and a burst advance strobe. Because write data arrives late, a read and a write can sit on consecutive cycles and the bus stays full.

A static mode input picks the pipeline depth. In pipelined mode read data passes through an output register and write data is taken two edges after its command. In flow-through mode read data comes straight from the array and write data is taken one edge after its command. A read that follows a write to the same word sees the new bytes, merged over the old ones under the byte mask. A second static input picks linear or interleaved order for four-beat bursts, and an advance input steps through a burst without a new address. An asynchronous output enable can switch the data drivers off at any time.

Top module: `zbt_sram`

## Requirements
- R1: After reset no command is pending. `dq_oe` is 0 and `dq_out` is all zeros until a read is issued.
- R2: In pipelined mode (`flow_mode`=0), a read sampled at edge k drives its word on `dq_out` with `dq_oe`=1 between edges k+1 and k+2.
- R3: In flow-through mode (`flow_mode`=1), a read sampled at edge k drives its word between edges k and k+1.
- R4: In pipelined mode, the write data for a write command sampled at edge k is taken from `dq_in` at edge k+2.
- R5: In flow-through mode, the write data for a write command sampled at edge k is taken from `dq_in` at edge k+1.
- R6: `bw_n[i]`=0 writes byte i, which is bits [9i+8:9i] of the word. `bw_n[i]`=1 leaves that byte unchanged.
- R7: A command is accepted only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0 (unless `adv`=1). If any one of them is inactive, no read drives the bus and no write changes the array.
- R8: `oe_n`=1 forces `dq_oe` to 0 and `dq_out` to zero at once, with no clock edge needed. `oe_n` does not affect the read pipeline.
- R9: With `burst_ilv`=0, the beats of a burst starting at address A use low address bits (A[1:0]+n) mod 4 for n = 0,1,2,3, and then wrap to n = 0. The upper address bits stay fixed.
- R10: With `burst_ilv`=1, the beats use low address bits A[1:0] XOR n.
- R11: A read issued right after a write to the same word, in either mode, returns the new data with no idle cycle in between.
- R12: A write whose data slot falls in deselected cycles still completes at its scheduled edge.
- R13: `adv`=1 with no burst in progress issues no access. A deselected cycle ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| flow_mode | input | 1 | Static: 1 selects flow-through, 0 selects pipelined |
| burst_ilv | input | 1 | Static: 1 selects interleaved burst order, 0 selects linear |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Continue the current burst |
| we_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | BYTES*9 | Write data |
| dq_out | output | BYTES*9 | Read data, zero when not driven |
| dq_oe | output | 1 | Data driver enable |

## Verification
The hardest case to reach is a pipelined read issued on the cycle right after a write to the same word. The array has not yet stored the write data, so the read word must be merged from the bus input while that data is being sampled. The stimulus reaches this case by issuing a full-word write and then a partial-mask write to the same word, followed immediately by a read of that word. Burst order, including the wrap after the fourth beat, is checked by writing each beat through the advance input and then reading each address on its own.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

    localparam int BYTE_W = 9;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_ord_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] beat_lsb(
        input logic [1:0] start,
        input logic [1:0] beat,
        input burst_ord_e ord
    );
        if (ord == ORD_XOR) begin
            return start ^ beat;
        end
        return start + beat;
    endfunction

endpackage

// File: rtl/zsr_burst.sv
module zsr_burst
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_ilv,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              iss_vld,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_a
);

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [1:0]        beat;
    } bst_t;

    bst_t       q, d;
    logic       sel;
    logic [1:0] nxt_beat;

    assign sel = ~ce_a_n & ce_b & ~ce_c_n;

    always_comb begin
        d        = q;
        iss_vld  = 1'b0;
        iss_wr   = q.wr;
        iss_a    = q.base;
        nxt_beat = q.beat + 2'd1;
        if (adv) begin
            if (q.act) begin
                d.beat  = nxt_beat;
                iss_vld = 1'b1;
                iss_a   = {q.base[ADDR_W-1:2],
                           beat_lsb(q.base[1:0], nxt_beat, burst_ord_e'(burst_ilv))};
            end
        end else if (sel) begin
            d.act   = 1'b1;
            d.wr    = ~we_n;
            d.base  = addr;
            d.beat  = 2'd0;
            iss_vld = 1'b1;
            iss_wr  = ~we_n;
            iss_a   = addr;
        end else begin
            d.act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R9/R10: each advance moves the beat counter by exactly one
    a_r9_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && q.act) |=> (q.beat == $past(q.beat) + 2'd1));

    // R13: a deselected cycle ends the burst
    a_r13_desel_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !sel) |=> !q.act);

endmodule

// File: rtl/zsr_array.sv
module zsr_array
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_a,
    input  logic [BYTES-1:0]         wr_bwn,
    input  logic [BYTES*BYTE_W-1:0]  wr_dat,
    input  logic [ADDR_W-1:0]        rd_a,
    output logic [BYTES*BYTE_W-1:0]  rd_dat
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !wr_bwn[g]) begin
                lane_mem[wr_a] <= wr_dat[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_dat[g*BYTE_W +: BYTE_W] = lane_mem[rd_a];
    end

endmodule

// File: rtl/zsr_fwd.sv
module zsr_fwd
    import zsr_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic                    hit,
    input  logic [BYTES-1:0]        bwn,
    input  logic [BYTES*BYTE_W-1:0] stored,
    input  logic [BYTES*BYTE_W-1:0] fresh,
    output logic [BYTES*BYTE_W-1:0] merged
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] = (hit && !bwn[g]) ?
            fresh[g*BYTE_W +: BYTE_W] : stored[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_mode,
    input  logic                    burst_ilv,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [BYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic [BYTES*BYTE_W-1:0] dq_in,
    output logic [BYTES*BYTE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DW = BYTES * BYTE_W;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] a;
        logic [BYTES-1:0]  bwn;
    } cmd_t;

    typedef struct packed {
        cmd_t          c1;    // command sampled at the last edge
        cmd_t          c2;    // command sampled one edge earlier
        logic          ovld;  // pipelined output register valid
        logic [DW-1:0] odat;
    } st_t;

    st_t               q, d;
    logic              iss_vld, iss_wr;
    logic [ADDR_W-1:0] iss_a;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_wa;
    logic [BYTES-1:0]  arr_bwn;
    logic [DW-1:0]     rd_raw, rd_fwd;
    logic              fwd_hit;
    logic              rd_vis;
    logic [DW-1:0]     rd_dat;

    zsr_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_ilv (burst_ilv),
        .ce_a_n    (ce_a_n),
        .ce_b      (ce_b),
        .ce_c_n    (ce_c_n),
        .adv       (adv),
        .we_n      (we_n),
        .addr      (addr),
        .iss_vld   (iss_vld),
        .iss_wr    (iss_wr),
        .iss_a     (iss_a)
    );

    // Late-write slot: one edge after the command in flow-through, two in pipelined.
    always_comb begin
        if (flow_mode) begin
            arr_we  = q.c1.vld & q.c1.wr;
            arr_wa  = q.c1.a;
            arr_bwn = q.c1.bwn;
        end else begin
            arr_we  = q.c2.vld & q.c2.wr;
            arr_wa  = q.c2.a;
            arr_bwn = q.c2.bwn;
        end
    end

    zsr_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
        .clk    (clk),
        .wr_en  (arr_we),
        .wr_a   (arr_wa),
        .wr_bwn (arr_bwn),
        .wr_dat (dq_in),
        .rd_a   (q.c1.a),
        .rd_dat (rd_raw)
    );

    // Pipelined read right behind a write to the same word: its data is on dq_in now.
    assign fwd_hit = ~flow_mode & q.c2.vld & q.c2.wr & (q.c2.a == q.c1.a);

    zsr_fwd #(.BYTES(BYTES)) u_fwd (
        .hit    (fwd_hit),
        .bwn    (q.c2.bwn),
        .stored (rd_raw),
        .fresh  (dq_in),
        .merged (rd_fwd)
    );

    always_comb begin
        d        = q;
        d.c1.vld = iss_vld;
        d.c1.wr  = iss_wr;
        d.c1.a   = iss_a;
        d.c1.bwn = bw_n;
        d.c2     = q.c1;
        d.ovld   = ~flow_mode & q.c1.vld & ~q.c1.wr;
        d.odat   = rd_fwd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_vis = flow_mode ? (q.c1.vld & ~q.c1.wr) : q.ovld;
    assign rd_dat = flow_mode ? rd_raw : q.odat;
    assign dq_oe  = rd_vis & ~oe_n;
    assign dq_out = dq_oe ? rd_dat : '0;

    // R2: a pipelined read reaches the output register one edge later
    a_r2_pipe_read_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && q.c1.vld && !q.c1.wr) |=> q.ovld);

    // R4: a pipelined write reaches the array port two edges after its command
    a_r4_pipe_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && q.c1.vld && q.c1.wr) |=> arr_we);

    // R5: a flow-through write reaches the array port one edge after its command
    a_r5_flow_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && iss_vld && iss_wr) |=> arr_we);

    // R7: an incomplete chip select issues nothing
    a_r7_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && (ce_a_n || !ce_b || ce_c_n)) |=> !q.c1.vld);

    // R8: output enable overrides the read pipeline without waiting for a clock edge
    always_comb begin
        if (rst_n && oe_n) begin
            a_r8_oe_off: assert (!dq_oe && dq_out == '0);
        end
    end

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flow_mode, burst_ilv;
    logic          ce_a_n, ce_b, ce_c_n, adv, we_n, oe_n;
    logic [NB-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_in, dq_out;
    logic          dq_oe;

    always #2.5 clk = ~clk;

    zbt_sram #(.ADDR_W(AW), .BYTES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_ilv(burst_ilv),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    errors = 0;
    int    checks = 0;
    string idle_tag = "R7";
    int    desel_pin = 1;

    // scoreboard queues
    int            rd_due[$];
    logic [DW-1:0] rd_exp[$];
    string         rd_tag[$];
    int            wd_due[$];
    logic [DW-1:0] wd_val[$];

    logic [DW-1:0] mdl [64];
    bit b_act, b_wr;
    int b_base, b_beat;

    function automatic logic [DW-1:0] pat(int n);
        return {9'(n * 7 + 1), 9'(n * 11 + 2), 9'(n * 13 + 3), 9'(n * 17 + 4)};
    endfunction

    function automatic int baddr(int base, int beat);
        int lsb;
        if (burst_ilv) lsb = (base & 3) ^ beat;
        else           lsb = (base + beat) & 3;
        return (base & ~3) | lsb;
    endfunction

    task automatic report(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Driver: one call = one clock cycle of command inputs.
    task automatic drive(bit sel, bit adv_i, bit wr, int a, logic [NB-1:0] bwn,
                         logic [DW-1:0] wd, bit oe_off, string tag);
        int k = cyc + 1;
        bit iss = 0;
        bit iwr = 0;
        int ia = 0;
        if (adv_i) begin
            if (b_act) begin
                b_beat = (b_beat + 1) % 4;
                iss = 1; iwr = b_wr; ia = baddr(b_base, b_beat);
            end
        end else if (sel) begin
            iss = 1; iwr = wr; ia = a;
            b_act = 1; b_wr = wr; b_base = a; b_beat = 0;
        end else begin
            b_act = 0;
        end
        if (iss && iwr) begin
            for (int i = 0; i < NB; i++)
                if (!bwn[i]) mdl[ia][i*9 +: 9] = wd[i*9 +: 9];
            wd_due.push_back(k + (flow_mode ? 1 : 2));
            wd_val.push_back(wd);
        end
        if (iss && !iwr) begin
            rd_due.push_back(k + (flow_mode ? 0 : 1));
            rd_exp.push_back(mdl[ia]);
            rd_tag.push_back(tag);
        end
        ce_a_n = !(sel || desel_pin != 0);
        ce_b   = sel || desel_pin != 1;
        ce_c_n = !(sel || desel_pin != 2);
        adv    = adv_i;
        we_n   = !wr;
        addr   = AW'(a);
        bw_n   = bwn;
        oe_n   = oe_off;
        if (wd_due.size() > 0 && wd_due[0] == k) begin
            dq_in = wd_val.pop_front();
            void'(wd_due.pop_front());
        end else begin
            dq_in = '0;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, '1, '0, 0, "");
    endtask

    task automatic wr_w(int a, logic [DW-1:0] v, logic [NB-1:0] bwn);
        drive(1, 0, 1, a, bwn, v, 0, "");
    endtask

    task automatic rd_w(int a, string tag);
        drive(1, 0, 0, a, '1, '0, 0, tag);
    endtask

    task automatic do_reset(bit fm, bit ilv);
        rst_n = 1'b0;
        flow_mode = fm; burst_ilv = ilv;
        ce_a_n = 1; ce_b = 0; ce_c_n = 1; adv = 0; we_n = 1;
        bw_n = '1; addr = '0; oe_n = 0; dq_in = '0;
        rd_due.delete(); rd_exp.delete(); rd_tag.delete();
        wd_due.delete(); wd_val.delete();
        b_act = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #0.5;
        // R1: nothing driven right after reset
        report(dq_oe === 1'b0, "R1", DW'(dq_oe), '0);
        report(dq_out === '0, "R1", dq_out, '0);
    endtask

    // Monitor: pops expected reads at their due cycle, otherwise expects a quiet bus.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (rd_due.size() > 0 && rd_due[0] < cyc) begin
                report(0, {rd_tag[0], " missed"}, '0, rd_exp[0]);
                void'(rd_due.pop_front()); void'(rd_exp.pop_front()); void'(rd_tag.pop_front());
            end
            if (rd_due.size() > 0 && rd_due[0] == cyc) begin
                if (oe_n === 1'b0)
                    report(dq_oe === 1'b1 && dq_out === rd_exp[0], rd_tag[0], dq_out, rd_exp[0]);
                else
                    report(dq_oe === 1'b0 && dq_out === '0, rd_tag[0], dq_out, '0);
                void'(rd_due.pop_front()); void'(rd_exp.pop_front()); void'(rd_tag.pop_front());
            end else begin
                report(dq_oe === 1'b0, idle_tag, DW'(dq_oe), '0);
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired cyc=%0d actual=running expected=finished", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // ---------- pipelined, linear ----------
        do_reset(0, 0);
        wr_w(0, pat(1), 4'h0);
        wr_w(1, pat(2), 4'h0);
        rd_w(0, "R2");                   // read right after write: R2, R11
        rd_w(1, "R2");
        wr_w(2, pat(3), 4'h0);
        rd_w(2, "R11");                  // forwarded from dq_in
        wr_w(3, pat(4), 4'h0);
        wr_w(3, pat(5), 4'b1010);        // R6: bytes 0 and 2 only
        rd_w(3, "R6");                   // merge on the forward path
        idle(); idle();
        rd_w(3, "R6");                   // merge from the array
        wr_w(4, pat(6), 4'h0);
        idle(); idle(); idle();
        rd_w(4, "R4");
        // R7: each enable pin dropped on its own
        for (int p = 0; p < 3; p++) begin
            desel_pin = p;
            wr_w(5, pat(10 + p), 4'h0);
            drive(0, 0, 1, 5, 4'h0, pat(20 + p), 0, "");
            drive(0, 0, 0, 5, '1, '0, 0, "");
            idle(); idle();
            rd_w(5, "R7");
            idle();
        end
        desel_pin = 1;
        // R12: data slot falls in deselected cycles
        wr_w(6, pat(30), 4'h0);
        idle(); idle();
        rd_w(6, "R12");
        // R8: output enable withdrawn while read data is due
        rd_w(0, "R8");
        drive(0, 0, 0, 0, '1, '0, 1, "");
        drive(0, 0, 0, 0, '1, '0, 1, "");
        rd_w(0, "R8");
        idle(); idle();
        // R9: linear burst write from 10: 10,11,8,9
        drive(1, 0, 1, 10, 4'h0, pat(40), 0, "");
        drive(0, 1, 0, 0, 4'h0, pat(41), 0, "");
        drive(0, 1, 0, 0, 4'h0, pat(42), 0, "");
        drive(0, 1, 0, 0, 4'h0, pat(43), 0, "");
        idle(); idle();
        for (int a = 8; a < 12; a++) rd_w(a, "R9");
        drive(1, 0, 0, 9, '1, '0, 0, "R9");
        for (int n = 0; n < 4; n++) drive(0, 1, 0, 0, '1, '0, 0, "R9");  // wraps back to 9
        idle(); idle();
        // R13: advance with no burst open
        idle_tag = "R13";
        drive(0, 1, 0, 0, '1, '0, 0, "");
        drive(0, 1, 1, 0, 4'h0, pat(50), 0, "");
        idle(); idle();
        rd_w(8, "R13");                  // array word untouched
        idle(); idle();
        idle_tag = "R7";

        // ---------- flow-through, interleaved ----------
        do_reset(1, 1);
        wr_w(0, pat(60), 4'h0);
        rd_w(0, "R3");                   // R3, R5, R11
        wr_w(1, pat(61), 4'h0);
        rd_w(1, "R5");
        rd_w(0, "R3");
        wr_w(1, pat(62), 4'b0101);       // R6: bytes 1 and 3
        rd_w(1, "R6");
        // R10: interleaved from 17: 17,16,19,18
        drive(1, 0, 1, 17, 4'h0, pat(70), 0, "");
        drive(0, 1, 0, 0, 4'h0, pat(71), 0, "");
        drive(0, 1, 0, 0, 4'h0, pat(72), 0, "");
        drive(0, 1, 0, 0, 4'h0, pat(73), 0, "");
        for (int a = 16; a < 20; a++) rd_w(a, "R10");
        drive(1, 0, 0, 18, '1, '0, 0, "R10");
        for (int n = 0; n < 3; n++) drive(0, 1, 0, 0, '1, '0, 0, "R10");
        // R12 in flow-through
        wr_w(2, pat(80), 4'h0);
        idle();
        rd_w(2, "R12");
        drive(0, 0, 0, 2, '1, '0, 0, "");
        repeat (4) idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule